// File: doc/BRIEF.md
# Nine-bit SPI command serializer

This block sends command and parameter bytes for a display controller over a serial link whose words are nine bits wide. Each word has a data/command flag in front of eight data bits. A command opcode travels with the flag at 0, and each parameter byte after it travels with the flag at 1. Words come in on a valid/ready stream. Each word carries a last marker, and that marker closes the transaction.

The link runs in one of two framings. In native framing every word is shifted out as its own nine-clock unit. Some hosts can only make byte-sized transfers. For them, packed framing gathers eight words and sends them as one unbroken 72-bit unit, which is nine whole bytes. A transaction that ends part way through a group has its remaining slots filled with no-operation command words. Packed framing may be selected even when native framing would work. The output side is a mode-0 serial port with a clock, a data line and an active-low select. A busy flag covers the whole transaction.

Top module: `spi9_cmd_serializer`

## Requirements
- R1: Native framing sends each word as 9 SCLK rising edges. The flag bit goes first (0 = command, 1 = data), then the data byte MSB first.
- R2: Packed framing concatenates eight words, each as flag then data MSB first, into one 72-bit unit. The unit is shifted with no gap between words, giving 72 rising edges per group.
- R3: If a packed transaction ends with fewer than eight words in its last group, that group is filled up to 72 bits with no-operation words (flag 0, byte 0x00, so nine 0 bits each).
- R4: The framing is taken from `packed_mode` when the first word of a transaction is accepted. Changes to `packed_mode` before select is released have no effect on the bit stream.
- R5: SCLK idles low. MOSI changes only while SCLK is low, so it is stable across every rising edge.
- R6: Every SCLK high phase lasts CLK_DIV/2 system cycles. Inside a 9-bit word (native) or a 72-bit group (packed), every low phase before a rising edge also lasts CLK_DIV/2 cycles.
- R7: `cs_n` goes low when the first word is accepted and stays low between words of the same transaction. It rises CLK_DIV system cycles after the last SCLK falling edge. SCLK is never high while `cs_n` is high.
- R8: `in_ready` is low while a word or group is being shifted. In packed framing, `in_ready` stays high while a group is still being gathered, and no SCLK edge occurs during that time.
- R9: `busy` rises with the first accepted word and falls in the same cycle that `cs_n` rises, so `busy` is always the inverse of `cs_n`.
- R10: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| packed_mode | input | 1 | 1 selects 72-bit packed framing, 0 selects native 9-bit framing |
| in_valid | input | 1 | Input word valid |
| in_dc | input | 1 | Word flag: 0 command, 1 data |
| in_data | input | 8 | Word data byte |
| in_last | input | 1 | Word ends the transaction |
| in_ready | output | 1 | Block can accept a word |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | A transaction is in progress |

## Verification
Two situations are hard to reach from the ports. The first is a packed transaction whose last group is only partly filled. The second is a change of `packed_mode` after a transaction has begun. To reach the first, the bench sweeps packed transactions from one to seventeen words, so the fill runs through every slot position and crosses group boundaries. To reach the second, it inverts `packed_mode` in the cycle right after the first word is accepted, then checks that the captured stream still matches the framing chosen at the start. Native transactions are run both back to back and with idle gaps between words, which checks that select is held and that the low phase stretches between words.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

    localparam int WORD_BITS = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_LOW,
        S_HIGH,
        S_TAIL
    } ser_state_e;

    typedef struct packed {
        logic       dc;
        logic [7:0] data;
    } word9_t;

endpackage

// File: rtl/spi9_half_timer.sv
module spi9_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi9_slot_insert.sv
module spi9_slot_insert #(
    parameter int SLOTS = 8,
    parameter int SW    = 4
) (
    input  logic [SLOTS*spi9_pkg::WORD_BITS-1:0] buf_i,
    input  logic [SW-1:0]                        slot,
    input  spi9_pkg::word9_t                     word_i,
    output logic [SLOTS*spi9_pkg::WORD_BITS-1:0] buf_o
);
    localparam int WB = spi9_pkg::WORD_BITS;

    // Slot 0 sits at the most significant end so it is shifted out first.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign buf_o[(SLOTS-1-g)*WB +: WB] =
            (slot == SW'(g)) ? word_i : buf_i[(SLOTS-1-g)*WB +: WB];
    end
endmodule

// File: rtl/spi9_cmd_serializer.sv
module spi9_cmd_serializer #(
    parameter int CLK_DIV     = 4,  // even, >= 2: system cycles per SCLK period
    parameter int GROUP_WORDS = 8   // packed group size, multiple of 8 for whole bytes
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       packed_mode,
    input  logic       in_valid,
    input  logic       in_dc,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi,
    output logic       busy
);
    import spi9_pkg::*;

    localparam int HALF  = CLK_DIV / 2;
    localparam int GBITS = GROUP_WORDS * WORD_BITS;
    localparam int BCW   = $clog2(GBITS + 1);
    localparam int SW    = $clog2(GROUP_WORDS + 1);

    typedef struct packed {
        ser_state_e       st;
        logic [GBITS-1:0] sh;
        logic [BCW-1:0]   bits;
        logic [SW-1:0]    fill;
        logic             pk;
        logic             last;
        logic             tail_half;
        logic             sclk;
        logic             cs_n;
        logic             busy;
    } ser_regs_t;

    ser_regs_t r_d, r_q;

    logic             tick;
    logic             run;
    logic [GBITS-1:0] ins_buf;
    logic [GBITS-1:0] base_buf;
    word9_t           in_word;

    assign in_word  = '{dc: in_dc, data: in_data};
    assign base_buf = (r_q.fill == '0) ? '0 : r_q.sh;
    assign run      = (r_q.st == S_LOW) || (r_q.st == S_HIGH) || (r_q.st == S_TAIL);

    spi9_half_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi9_slot_insert #(.SLOTS(GROUP_WORDS), .SW(SW)) u_insert (
        .buf_i  (base_buf),
        .slot   (r_q.fill),
        .word_i (in_word),
        .buf_o  (ins_buf)
    );

    always_comb begin
        logic mode_now;
        r_d      = r_q;
        in_ready = (r_q.st == S_IDLE) || (r_q.st == S_WAIT);
        mode_now = (r_q.st == S_IDLE) ? packed_mode : r_q.pk;

        unique case (r_q.st)
            S_IDLE, S_WAIT: begin
                if (in_valid) begin
                    r_d.pk   = mode_now;
                    r_d.cs_n = 1'b0;
                    r_d.busy = 1'b1;
                    r_d.last = in_last;
                    r_d.sh   = ins_buf;
                    if (!mode_now) begin
                        r_d.bits = BCW'(WORD_BITS);
                        r_d.fill = '0;
                        r_d.st   = S_LOW;
                    end else if (in_last || r_q.fill == SW'(GROUP_WORDS - 1)) begin
                        r_d.bits = BCW'(GBITS);
                        r_d.fill = '0;
                        r_d.st   = S_LOW;
                    end else begin
                        r_d.fill = r_q.fill + 1'b1;
                        r_d.st   = S_WAIT;
                    end
                end
            end
            S_LOW: begin
                if (tick) begin
                    r_d.sclk = 1'b1;
                    r_d.st   = S_HIGH;
                end
            end
            S_HIGH: begin
                if (tick) begin
                    r_d.sclk = 1'b0;
                    r_d.sh   = r_q.sh << 1;
                    r_d.bits = r_q.bits - 1'b1;
                    if (r_q.bits == BCW'(1)) begin
                        r_d.st        = r_q.last ? S_TAIL : S_WAIT;
                        r_d.tail_half = 1'b0;
                    end else begin
                        r_d.st = S_LOW;
                    end
                end
            end
            S_TAIL: begin
                if (tick) begin
                    if (r_q.tail_half) begin
                        r_d.st   = S_IDLE;
                        r_d.cs_n = 1'b1;
                        r_d.busy = 1'b0;
                        r_d.pk   = 1'b0;
                        r_d.last = 1'b0;
                    end else begin
                        r_d.tail_half = 1'b1;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, sh: '0, bits: '0, fill: '0, pk: 1'b0,
                     last: 1'b0, tail_half: 1'b0, sclk: 1'b0, cs_n: 1'b1,
                     busy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk = r_q.sclk;
    assign cs_n = r_q.cs_n;
    assign busy = r_q.busy;
    assign mosi = r_q.sh[GBITS-1];
endmodule

// File: rtl/spi9_cmd_serializer_chk.sv
module spi9_cmd_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy
);
    p_mosi_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sclk)
        else $error("mosi changed while sclk high");

    p_mosi_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi))
        else $error("mosi changed on sclk rise");

    p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n)
        else $error("sclk high outside select");

    p_release_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sclk && !$past(sclk)))
        else $error("select released next to sclk activity");

    p_ready_low_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !in_ready)
        else $error("ready while shifting");

    p_busy_tracks_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(cs_n))
        else $error("busy fell apart from select release");

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $rose(busy))
        else $error("busy not raised with select");
endmodule

bind spi9_cmd_serializer spi9_cmd_serializer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .busy     (busy)
);

// File: tb/spi9_cmd_serializer_test.sv
`timescale 1ns/1ps
module spi9_cmd_serializer_test;
    localparam int CLK_DIV = 4;
    localparam int HALF    = CLK_DIV / 2;
    localparam int GBITS   = 72;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       packed_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_dc = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready, sclk, cs_n, mosi, busy;

    int n_tests = 0;
    int n_fail  = 0;

    bit cap_q[$];
    bit exp_q[$];

    int  since_rise = 0, since_fall = 0;
    int  bit_in_unit = 0, unit_bits = 9, rise_count = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always #10 clk = ~clk;

    spi9_cmd_serializer #(.CLK_DIV(CLK_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .packed_mode(packed_mode),
        .in_valid(in_valid), .in_dc(in_dc), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Port monitor, sampled on the falling system clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            since_rise++;
            since_fall++;
            if (sclk && !prev_sclk) begin
                rise_count++;
                if (!cs_n) cap_q.push_back(mosi);
                if (bit_in_unit != 0)
                    check(since_fall == HALF, "R6", "low phase", since_fall, HALF);
                check(!in_ready, "R8", "ready while shifting", in_ready, 0);
                bit_in_unit = (bit_in_unit + 1) % unit_bits;
                since_rise = 0;
            end
            if (!sclk && prev_sclk) begin
                check(since_rise == HALF, "R6", "high phase", since_rise, HALF);
                since_fall = 0;
            end
            if (cs_n && !prev_cs) begin
                check(since_fall == CLK_DIV, "R7", "release delay", since_fall, CLK_DIV);
                check(!busy, "R9", "busy at release", busy, 0);
            end
            if (!cs_n && prev_cs)
                check(busy, "R9", "busy at select", busy, 1);
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    task automatic run_txn(input bit start_mode, input int n, input int seed,
                           input int gap, input bit flip, input string tag);
        int mism;
        int rc0;
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'(seed * 29 + i * 71 + 5);
            exp_q.push_back(bit'(i % 5 != 0));
            for (int b = 7; b >= 0; b--) exp_q.push_back(d[b]);
        end
        if (start_mode)
            while (exp_q.size() % GBITS != 0) exp_q.push_back(1'b0);

        @(negedge clk);
        cap_q.delete();
        bit_in_unit = 0;
        unit_bits   = start_mode ? GBITS : 9;
        packed_mode = start_mode;
        rc0 = rise_count;
        for (int i = 0; i < n; i++) begin
            int waited = 0;
            in_valid = 1'b1;
            in_dc    = (i % 5 != 0);
            in_data  = 8'(seed * 29 + i * 71 + 5);
            in_last  = (i == n - 1);
            while (!in_ready) begin
                waited++;
                @(negedge clk);
            end
            if (i > 0)
                check(!cs_n, "R7", "select held between words", cs_n, 0);
            if (start_mode && !flip && (i % 8 != 0)) begin
                check(waited == 0, "R8", "ready while gathering", waited, 0);
                if (i < 8)
                    check(rise_count == rc0, "R8", "edges while gathering",
                          rise_count - rc0, 0);
            end
            if (!start_mode && !flip && gap == 0 && i > 0)
                check(waited > 0, "R8", "ready during native word", waited, 1);
            @(negedge clk);
            if (flip && i == 0) packed_mode = ~start_mode;
            in_valid = 1'b0;
            in_last  = 1'b0;
            repeat (gap) @(negedge clk);
        end
        while (busy) @(negedge clk);
        check(cap_q.size() == exp_q.size(), tag, "bit count", cap_q.size(), exp_q.size());
        mism = 0;
        for (int k = 0; k < exp_q.size() && k < cap_q.size(); k++)
            if (cap_q[k] != exp_q[k]) mism++;
        check(mism == 0, tag, "bit mismatches", mism, 0);
        packed_mode = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(cs_n == 1'b1,  "R10", "cs_n", cs_n, 1);
        check(sclk == 1'b0,  "R10", "sclk", sclk, 0);
        check(mosi == 1'b0,  "R10", "mosi", mosi, 0);
        check(busy == 1'b0,  "R10", "busy", busy, 0);
        check(in_ready == 1'b1, "R10", "in_ready", in_ready, 1);

        // R1: native framing, single word and multi-word, tight and gapped
        for (int n = 1; n <= 5; n++) begin
            run_txn(1'b0, n, n, 0, 1'b0, "R1");
            run_txn(1'b0, n, n + 40, 3, 1'b0, "R1");
        end
        // R2 / R3: packed sweep across group boundaries
        for (int n = 1; n <= 17; n++)
            run_txn(1'b1, n, n * 3, (n % 3), 1'b0, (n % 8 == 0) ? "R2" : "R3");
        // R4: framing change after the first word is ignored
        run_txn(1'b0, 4, 77, 1, 1'b1, "R4");
        run_txn(1'b1, 5, 91, 1, 1'b1, "R4");
        run_txn(1'b1, 10, 13, 0, 1'b1, "R4");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule